// File: doc/BRIEF.md
# EDO DRAM Page-Mode Read Sequencer

This block drives the row and column strobes, the output-enable and write-enable strobes and the multiplexed address of an EDO DRAM for read accesses. A host presents a full word address with a valid/ready handshake and gets back one data word with a single-cycle response pulse. The block keeps the last opened row. A read to that row skips the row phases and starts at the column setup (on-page access). A read to any other row first raises the row strobe and runs a full precharge (off-page access).

The block runs on a clock at twice the bus rate, so one clock period (a tick) is half a bus cycle T and strobes can move on half-cycle boundaries. Four 2-bit wait counts stretch the precharge, row hold, data access and CAS precharge phases, each by two ticks per wait. A fifth 2-bit count sets the idle bus cycles inserted when a write follows a read. All five counts are captured when a request is accepted. Write data timing is not part of this block. For a write request it only performs the read-to-write turnaround: it releases the output enable, waits, and then pulses the response to say that write data may be driven.

Top module: `edo_read_seq`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n, dram_oe_n and dram_we_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: An off-page read from a closed row holds dram_ras_n high with the row address (req_addr bits above the column bits) on dram_ma for 1+2*prech ticks before dram_ras_n falls.
- R3: After dram_ras_n falls, the row address stays on dram_ma for 1+2*rowhold ticks. The column address (the low COL_W bits of req_addr, zero-extended) then appears with dram_oe_n low, and dram_cas_n falls one tick later.
- R4: dram_cas_n stays low for exactly 1+2*access ticks, and the column address is held on dram_ma for all of that time.
- R5: In the tick in which dram_cas_n returns high, rsp_valid is 1 for one tick and rsp_data carries the dram_dq value sampled at that edge.
- R6: After that response, dram_cas_n stays high and req_ready stays 0 for 2*casprech ticks in total, counting the response tick. req_ready then returns to 1 and the outputs hold.
- R7: A read whose row equals the open row leaves dram_ras_n low and starts directly with the one-tick column setup.
- R8: A read to a different row while a row is open raises dram_ras_n and dram_oe_n in the first tick and runs the full precharge of R2.
- R9: Wait counts are taken from the cfg inputs in the accepting cycle. Changing the cfg inputs during an access does not change that access's strobe timing.
- R10: A write request accepted while dram_oe_n is low raises dram_oe_n for 1+2*idle ticks and then pulses rsp_valid. With dram_oe_n already high, rsp_valid pulses in the next tick. Neither case moves dram_ras_n, dram_cas_n or dram_ma.
- R11: dram_cas_n is never low while dram_ras_n is high, and dram_we_n is always 1.
- R12: dram_oe_n goes low at the column setup of a read and stays low until a write turnaround or an off-page precharge raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write turnaround request, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| cfg_prech | input | 2 | Precharge wait count |
| cfg_rowhold | input | 2 | Row hold wait count |
| cfg_access | input | 2 | Data access wait count |
| cfg_casprech | input | 2 | CAS precharge wait count |
| cfg_idle | input | 2 | Read-to-write idle count |
| rsp_valid | output | 1 | One-tick response pulse |
| rsp_data | output | DATA_W | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ma | output | ROW_W | Multiplexed address |
| dram_dq | input | DATA_W | Read data from the memory |

## Verification
The assertions assume that the memory places its data on dram_dq before the edge at which CAS rises. They also assume that the host holds req_valid, req_write, req_addr and the cfg inputs steady from the falling clock edge until the accepting rising edge. The bench drives every input on the falling edge and models dram_dq as a pure function of dram_ma, so the data is already settled at that edge. Requests are issued only in a tick where the reference model expects req_ready. The cfg inputs are deliberately disturbed only after acceptance, to exercise the capture rule.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    localparam int WAIT_W = 2;
    localparam int CNT_W  = WAIT_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROWH,
        ST_COLS,
        ST_CASL,
        ST_CASH,
        ST_TURN
    } seq_st_e;

    typedef struct packed {
        logic [WAIT_W-1:0] prech;
        logic [WAIT_W-1:0] rowhold;
        logic [WAIT_W-1:0] access;
        logic [WAIT_W-1:0] casprech;
        logic [WAIT_W-1:0] idle;
    } wait_set_t;

    typedef struct packed {
        logic [CNT_W-1:0] pre_last;
        logic [CNT_W-1:0] rowh_last;
        logic [CNT_W-1:0] casl_last;
        logic [CNT_W-1:0] cash_last;
        logic             cash_skip;
        logic [CNT_W-1:0] turn_last;
    } phase_len_t;

endpackage

// File: rtl/edo_phase_len.sv
module edo_phase_len
    import edo_seq_pkg::*;
(
    input  wait_set_t  waits,
    output phase_len_t len
);
    // A phase of 1+2w ticks loads 2w into a down-counter that ends at zero.
    always_comb begin
        len.pre_last  = {waits.prech, 1'b0};
        len.rowh_last = {waits.rowhold, 1'b0};
        len.casl_last = {waits.access, 1'b0};
        len.cash_skip = (waits.casprech == '0);
        len.cash_last = {waits.casprech, 1'b0} - CNT_W'(1);
        len.turn_last = {waits.idle, 1'b0};
    end
endmodule

// File: rtl/edo_page_cmp.sv
module edo_page_cmp #(
    parameter int ROW_W = 10
) (
    input  logic             row_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             page_hit
);
    always_comb begin
        page_hit = row_open && (open_row == req_row);
    end
endmodule

// File: rtl/edo_read_seq.sv
module edo_read_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [WAIT_W-1:0]      cfg_prech,
    input  logic [WAIT_W-1:0]      cfg_rowhold,
    input  logic [WAIT_W-1:0]      cfg_access,
    input  logic [WAIT_W-1:0]      cfg_casprech,
    input  logic [WAIT_W-1:0]      cfg_idle,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_oe_n,
    output logic                   dram_we_n,
    output logic [ROW_W-1:0]       dram_ma,
    input  logic [DATA_W-1:0]      dram_dq
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int MA_W   = ROW_W;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        wait_set_t         w;
        logic              open;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ras_n;
        logic              cas_n;
        logic              oe_n;
        logic [MA_W-1:0]   ma;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    wait_set_t  cfg_w;
    phase_len_t cfg_len, lat_len;
    logic       page_hit;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    always_comb begin
        cfg_w.prech    = cfg_prech;
        cfg_w.rowhold  = cfg_rowhold;
        cfg_w.access   = cfg_access;
        cfg_w.casprech = cfg_casprech;
        cfg_w.idle     = cfg_idle;
    end

    edo_phase_len u_len_cfg (.waits(cfg_w), .len(cfg_len));
    edo_phase_len u_len_lat (.waits(r_q.w), .len(lat_len));

    edo_page_cmp #(.ROW_W(ROW_W)) u_page (
        .row_open (r_q.open),
        .open_row (r_q.row),
        .req_row  (req_row),
        .page_hit (page_hit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.w = cfg_w;
                    if (req_write) begin
                        if (!r_q.oe_n) begin
                            r_d.st   = ST_TURN;
                            r_d.oe_n = 1'b1;
                            r_d.cnt  = cfg_len.turn_last;
                        end else begin
                            r_d.rsp_v = 1'b1;
                        end
                    end else begin
                        r_d.col = req_col;
                        if (page_hit) begin
                            r_d.st   = ST_COLS;
                            r_d.ma   = MA_W'(req_col);
                            r_d.oe_n = 1'b0;
                            r_d.cnt  = '0;
                        end else begin
                            r_d.st    = ST_PRE;
                            r_d.ras_n = 1'b1;
                            r_d.oe_n  = 1'b1;
                            r_d.ma    = req_row;
                            r_d.row   = req_row;
                            r_d.open  = 1'b1;
                            r_d.cnt   = cfg_len.pre_last;
                        end
                    end
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_ROWH;
                    r_d.ras_n = 1'b0;
                    r_d.cnt   = lat_len.rowh_last;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_ROWH: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_COLS;
                    r_d.ma   = MA_W'(r_q.col);
                    r_d.oe_n = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_COLS: begin
                r_d.st    = ST_CASL;
                r_d.cas_n = 1'b0;
                r_d.cnt   = lat_len.casl_last;
            end
            ST_CASL: begin
                if (r_q.cnt == '0) begin
                    r_d.cas_n = 1'b1;
                    r_d.rsp_v = 1'b1;
                    r_d.rdata = dram_dq;
                    if (lat_len.cash_skip) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st  = ST_CASH;
                        r_d.cnt = lat_len.cash_last;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_CASH: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_TURN: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.rsp_v = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.oe_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_v;
    assign rsp_data   = r_q.rdata;
    assign dram_ras_n = r_q.ras_n;
    assign dram_cas_n = r_q.cas_n;
    assign dram_oe_n  = r_q.oe_n;
    assign dram_we_n  = 1'b1;
    assign dram_ma    = r_q.ma;

    // Strobe-width monitors, independent of the sequencer counter.
    logic [3:0] cas_lo_cnt;
    logic [7:0] ras_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_lo_cnt <= '0;
            ras_hi_cnt <= '0;
        end else begin
            if (!dram_cas_n) begin
                if (cas_lo_cnt != 4'hF) cas_lo_cnt <= cas_lo_cnt + 4'd1;
            end else begin
                cas_lo_cnt <= '0;
            end
            if (dram_ras_n) begin
                if (ras_hi_cnt != 8'hFF) ras_hi_cnt <= ras_hi_cnt + 8'd1;
            end else begin
                ras_hi_cnt <= '0;
            end
        end
    end

    p_cas_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> (cas_lo_cnt == 4'(1 + 2 * r_q.w.access)));

    p_prech_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= 8'(1 + 2 * r_q.w.prech)));

    p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_ma));

    p_col_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_ma));

    p_cas_under_ras_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    p_col_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !$rose(dram_cas_n)) |=> $stable(dram_ma));

endmodule

// File: tb/sim_edo_read_seq.sv
module sim_edo_read_seq;
    import edo_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int MA_W   = ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] cfg_prech = '0, cfg_rowhold = '0, cfg_access = '0, cfg_casprech = '0, cfg_idle = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n;
    logic [MA_W-1:0] dram_ma;
    logic [DATA_W-1:0] dram_dq;
    logic [DATA_W-1:0] salt = 16'h3C5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_read_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr),
        .cfg_prech(cfg_prech), .cfg_rowhold(cfg_rowhold), .cfg_access(cfg_access),
        .cfg_casprech(cfg_casprech), .cfg_idle(cfg_idle),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
        .dram_we_n(dram_we_n), .dram_ma(dram_ma), .dram_dq(dram_dq)
    );

    // Memory model: data is a fixed function of the address bus.
    assign dram_dq = DATA_W'({dram_ma, dram_ma}) ^ salt;

    typedef struct packed {
        logic ras, cas, oe, rdy, rv, rd;
        logic [MA_W-1:0] ma;
        logic [DATA_W-1:0] dat;
    } ent_t;

    ent_t  expq[$];
    string tagq[$];
    ent_t  hold;
    logic  m_open = 1'b0;
    logic [ROW_W-1:0] m_row = '0;
    logic  last_rdy = 1'b1;
    string tag_ovr = "";
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic push(input logic ras, input logic cas, input logic oe, input logic [MA_W-1:0] ma,
                        input logic rdy, input logic rv, input logic rd, input logic [DATA_W-1:0] dat,
                        input string tag);
        ent_t e;
        e.ras = ras; e.cas = cas; e.oe = oe; e.ma = ma; e.rdy = rdy; e.rv = rv; e.rd = rd; e.dat = dat;
        expq.push_back(e);
        tagq.push_back((tag_ovr != "") ? tag_ovr : tag);
        hold = e;
        hold.rdy = 1'b1; hold.rv = 1'b0; hold.rd = 1'b0;
    endtask

    task automatic step();
        ent_t e;
        string tag;
        @(posedge clk);
        @(negedge clk);
        if (expq.size() > 0) begin
            e = expq.pop_front();
            tag = tagq.pop_front();
        end else begin
            e = hold;
            tag = "R6";
        end
        chk(tag, "ras_n", 32'(dram_ras_n), 32'(e.ras));
        chk(tag, "cas_n", 32'(dram_cas_n), 32'(e.cas));
        chk((tag_ovr != "") ? tag : "R12", "oe_n", 32'(dram_oe_n), 32'(e.oe));
        chk(tag, "ma", 32'(dram_ma), 32'(e.ma));
        chk(tag, "req_ready", 32'(req_ready), 32'(e.rdy));
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
        chk("R11", "we_n", 32'(dram_we_n), 32'd1);
        if (e.rd) chk("R5", "rsp_data", 32'(rsp_data), 32'(e.dat));
        last_rdy = e.rdy;
    endtask

    task automatic drain();
        while (expq.size() > 0) step();
        if (!last_rdy) step();
    endtask

    // Read access; scramble disturbs the cfg inputs after acceptance.
    task automatic do_read(input logic [ADDR_W-1:0] addr, input int wrp, input int wrh,
                           input int wda, input int wcp, input bit scramble);
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [MA_W-1:0]  cma;
        logic [DATA_W-1:0] dexp;
        bit hit;
        row = addr[ADDR_W-1:COL_W];
        col = addr[COL_W-1:0];
        cma = MA_W'(col);
        dexp = DATA_W'({cma, cma}) ^ salt;
        hit = m_open && (m_row == row);
        if (!hit) begin
            for (int k = 0; k < 1 + 2*wrp; k++) push(1, 1, 1, row, 0, 0, 0, '0, m_open ? "R8" : "R2");
            for (int k = 0; k < 1 + 2*wrh; k++) push(0, 1, 1, row, 0, 0, 0, '0, "R3");
            m_open = 1'b1;
            m_row = row;
        end
        push(0, 1, 0, cma, 0, 0, 0, '0, hit ? "R7" : "R3");
        for (int k = 0; k < 1 + 2*wda; k++) push(0, 0, 0, cma, 0, 0, 0, '0, "R4");
        if (wcp == 0) begin
            push(0, 1, 0, cma, 1, 1, 1, dexp, "R5");
        end else begin
            push(0, 1, 0, cma, 0, 1, 1, dexp, "R5");
            for (int k = 0; k < 2*wcp - 1; k++) push(0, 1, 0, cma, 0, 0, 0, '0, "R6");
        end
        req_addr = addr; req_write = 1'b0; req_valid = 1'b1;
        cfg_prech = 2'(wrp); cfg_rowhold = 2'(wrh); cfg_access = 2'(wda); cfg_casprech = 2'(wcp);
        step();
        req_valid = 1'b0;
        if (scramble) begin
            cfg_prech = ~cfg_prech; cfg_rowhold = ~cfg_rowhold;
            cfg_access = ~cfg_access; cfg_casprech = ~cfg_casprech;
        end
        drain();
    endtask

    task automatic do_write(input int idle);
        if (hold.oe == 1'b0) begin
            for (int k = 0; k < 1 + 2*idle; k++) push(hold.ras, 1, 1, hold.ma, 0, 0, 0, '0, "R10");
            push(hold.ras, 1, 1, hold.ma, 1, 1, 0, '0, "R10");
        end else begin
            push(hold.ras, 1, 1, hold.ma, 1, 1, 0, '0, "R10");
        end
        req_write = 1'b1; req_valid = 1'b1; cfg_idle = 2'(idle);
        step();
        req_valid = 1'b0; req_write = 1'b0; cfg_idle = ~cfg_idle;
        drain();
    endtask

    initial begin
        hold = '0;
        hold.ras = 1; hold.cas = 1; hold.oe = 1; hold.rdy = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ras_n", 32'(dram_ras_n), 32'd1);
        chk("R1", "cas_n", 32'(dram_cas_n), 32'd1);
        chk("R1", "oe_n", 32'(dram_oe_n), 32'd1);
        chk("R1", "we_n", 32'(dram_we_n), 32'd1);
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        step();
        step();

        do_read({10'h055, 9'h012}, 0, 0, 0, 0, 0);   // R2 closed row, minimum waits
        do_read({10'h055, 9'h1A3}, 1, 2, 3, 1, 0);   // R7 page hit
        do_read({10'h055, 9'h0F0}, 3, 3, 3, 3, 0);   // R7 hit, maximum waits
        salt = 16'h9E37;
        do_read({10'h2AA, 9'h101}, 2, 1, 0, 2, 0);   // R8 miss with open row
        do_write(2);                                  // R10 turnaround after read
        do_write(1);                                  // R10 OE already released
        do_read({10'h2AA, 9'h0C3}, 0, 0, 1, 0, 0);   // R12 hit re-enables OE
        tag_ovr = "R9";
        do_read({10'h133, 9'h077}, 1, 0, 2, 1, 1);   // R9 miss, cfg disturbed
        do_read({10'h133, 9'h078}, 0, 3, 1, 2, 1);   // R9 hit, cfg disturbed
        tag_ovr = "";
        do_write(0);
        begin
            int lcg = 12345;
            for (int n = 0; n < 40; n++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
                salt = 16'(lcg);
                if ((lcg & 7) == 0) begin
                    do_write((lcg >> 4) & 3);
                end else begin
                    do_read({10'((lcg >> 8) & 3), 9'(lcg >> 12)},
                            (lcg >> 3) & 3, (lcg >> 5) & 3, (lcg >> 21) & 3, (lcg >> 23) & 3, 0);
                end
            end
        end
        repeat (3) step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule